// File: doc/BRIEF.md
# Threshold Zero Suppression Formatter

This block sits behind the readout of one 128-channel front-end chip. For every trigger it takes in a full set of pedestal-subtracted samples, channel by channel, with a configured number of time bins per channel. It decides for each channel whether the channel carries signal and drops the ones that do not. It then sends out one framed record: a fixed chip header followed by one record for each channel that passed. A channel record holds all of that channel's samples.

The cut compares the mean charge of a channel with that channel's noise level scaled by a user factor. The comparison needs no divider, because both sides are multiplied by the bin count: 16·Σsamples ≥ N·σ·A, with A in unsigned Q4.4. The per-channel noise values are loaded through a small write port. The factor, the bin count, the chip identifier and a bypass switch are static configuration inputs, captured when a trigger starts. The whole trigger is stored before any output is sent, so the header can carry the final count of channels that passed.

The controller is a state machine with six states:

- **IDLE**: waits for a first-flagged beat.
- **COLLECT**: accepts the remaining beats and sums each channel.
- **HEAD**: sends the four header words.
- **SCAN**: steps one channel per cycle to the next kept channel.
- **CHID**: sends a channel-record identifier word.
- **SAMP**: sends that channel's samples.

Its transitions are:

- IDLE→COLLECT on a first-flagged beat.
- COLLECT→HEAD when the last sample of channel 127 is accepted.
- HEAD→IDLE after header word 3 when no channel passed; HEAD→SCAN otherwise.
- SCAN→CHID on a kept channel.
- CHID→SAMP when the identifier word is accepted.
- SAMP→SCAN at the end of a channel that is not the last kept one.
- SAMP→IDLE at the end of the last kept channel.

Top module: `zs_formatter`

## Requirements
- R1: While reset is low and right after it is released, m_valid and m_last are 0 and s_ready is 1. A reset in the middle of a trigger abandons that trigger.
- R2: In IDLE, an input beat with s_first = 0 is accepted and discarded. A trigger starts only with a beat that has s_first = 1, and that beat is sample 0 of channel 0.
- R3: A trigger is 128 × Neff beats, sent channel 0 first with samples in time order. s_ready is 0 from the moment the last beat is accepted until the last output word is accepted.
- R4: A channel is kept when 16·S ≥ Neff·σ·A. S is the sum of the channel's samples, each taken as a 13-bit two's-complement value. σ is the channel's 8-bit noise value. A is the 8-bit Q4.4 factor.
- R5: With cfg_bypass = 1 captured at trigger start, all 128 channels are kept.
- R6: The header is four 16-bit words. Word 0 is {chip id byte, kept-channel count byte}. Word 1 is {Neff byte, error byte}. Words 2 and 3 are 0. The high byte of each word is listed first.
- R7: Each kept channel, in ascending channel order, sends the word {8'h00, channel number} and then Neff words {3'b000, sample[12:0]}.
- R8: m_last is 1 only on the final word of the frame. That is the last sample of the highest kept channel, or header word 3 when no channel is kept.
- R9: Error byte bit 0 is 1 when s_nsamp on the first beat is above 16 or differs from cfg_nsamp. All other error bits are 0.
- R10: While m_valid = 1 and m_ready = 0, m_data and m_last stay unchanged.
- R11: A write with cfg_std_we = 1 sets the noise value of channel cfg_std_addr. Later triggers use the new value.
- R12: Neff equals cfg_nsamp, limited to 16 at the top and raised to 1 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_chip_id | input | 4 | Chip identifier written into the header |
| cfg_nsamp | input | 8 | Configured time bins per channel |
| cfg_factor | input | 8 | Cut factor A, unsigned Q4.4 |
| cfg_bypass | input | 1 | Keep every channel |
| cfg_std_we | input | 1 | Noise table write strobe |
| cfg_std_addr | input | 7 | Noise table channel index |
| cfg_std_data | input | 8 | Noise value to write |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted |
| s_first | input | 1 | Marks the first beat of a trigger |
| s_nsamp | input | 8 | Bin count announced by the source, read on the first beat |
| s_data | input | 13 | Pedestal-subtracted sample, two's complement |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Output word accepted |
| m_data | output | 16 | Output word |
| m_last | output | 1 | Final word of the frame |

## Verification
The bound checker watches several rules on every cycle:

- Input acceptance and output never overlap.
- m_last appears only together with m_valid.
- The output holds steady under backpressure.
- The block returns to accepting input right after the final word.
- Sample words carry zero padding above bit 12.

Other behaviour can only be shown by the bench's scenarios, which compare every output word against a model of the requirements. This covers the cut itself, including exact equality at the threshold, and the kept count in the header. It also covers bypass, the empty frame, the error flag, clamping of the bin count, discarding of stray beats, noise table updates and reset in the middle of a trigger.

// File: rtl/zs_pkg.sv
package zs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_HEAD,
        ST_SCAN,
        ST_CHID,
        ST_SAMP
    } zs_state_e;
endpackage

// File: rtl/zs_std_table.sv
module zs_std_table #(
    parameter int NCHAN = 128,
    parameter int STDW  = 8,
    localparam int CHW  = $clog2(NCHAN)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [CHW-1:0]  waddr,
    input  logic [STDW-1:0] wdata,
    input  logic [CHW-1:0]  raddr,
    output logic [STDW-1:0] rdata
);
    logic [STDW-1:0] mem [NCHAN];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/zs_sample_store.sv
module zs_sample_store #(
    parameter int NCHAN = 128,
    parameter int MAXS  = 16,
    parameter int SW    = 13,
    localparam int CHW  = $clog2(NCHAN),
    localparam int SIW  = $clog2(MAXS),
    localparam int AW   = $clog2(NCHAN * MAXS)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [CHW-1:0] wch,
    input  logic [SIW-1:0] wsi,
    input  logic [SW-1:0]  wdata,
    input  logic [CHW-1:0] rch,
    input  logic [SIW-1:0] rsi,
    output logic [SW-1:0]  rdata
);
    logic [SW-1:0] mem [NCHAN * MAXS];
    logic [AW-1:0] waddr, raddr;

    assign waddr = AW'(wch) * AW'(MAXS) + AW'(wsi);
    assign raddr = AW'(rch) * AW'(MAXS) + AW'(rsi);

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/zs_cut.sv
module zs_cut #(
    parameter int SUMW = 17,
    parameter int NSW  = 5,
    parameter int STDW = 8,
    parameter int FW   = 8,
    parameter int FRAC = 4,
    localparam int PW   = NSW + STDW + FW,
    localparam int LW   = SUMW + FRAC,
    localparam int CMPW = ((PW > LW) ? PW : LW) + 1
) (
    input  logic signed [SUMW-1:0] sum,
    input  logic [NSW-1:0]         nbins,
    input  logic [STDW-1:0]        sigma,
    input  logic [FW-1:0]          factor,
    input  logic                   bypass,
    output logic                   keep
);
    logic [PW-1:0]          prod;
    logic signed [CMPW-1:0] lhs;
    logic signed [CMPW-1:0] rhs;

    always_comb begin
        prod = PW'(nbins) * PW'(sigma) * PW'(factor);
        lhs  = CMPW'(sum) <<< FRAC;
        rhs  = signed'(CMPW'(prod));
        keep = bypass || (lhs >= rhs);
    end
endmodule

// File: rtl/zs_formatter.sv
module zs_formatter
    import zs_pkg::*;
#(
    parameter int NCHAN = 128,
    parameter int MAXS  = 16,
    parameter int SW    = 13,
    parameter int STDW  = 8,
    parameter int FW    = 8,
    parameter int FRAC  = 4,
    parameter int IDW   = 4,
    localparam int CHW  = $clog2(NCHAN),
    localparam int SIW  = $clog2(MAXS),
    localparam int NSW  = SIW + 1,
    localparam int SUMW = SW + SIW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDW-1:0]  cfg_chip_id,
    input  logic [7:0]      cfg_nsamp,
    input  logic [FW-1:0]   cfg_factor,
    input  logic            cfg_bypass,
    input  logic            cfg_std_we,
    input  logic [CHW-1:0]  cfg_std_addr,
    input  logic [STDW-1:0] cfg_std_data,
    input  logic            s_valid,
    output logic            s_ready,
    input  logic            s_first,
    input  logic [7:0]      s_nsamp,
    input  logic [SW-1:0]   s_data,
    output logic            m_valid,
    input  logic            m_ready,
    output logic [15:0]     m_data,
    output logic            m_last
);
    localparam logic [7:0] MAXS_B = 8'(MAXS);

    zs_state_e state, state_nx;

    logic [CHW-1:0]         ch_i, och, last_keep;
    logic [SIW-1:0]         si, osi;
    logic [1:0]             hw;
    logic signed [SUMW-1:0] acc, acc_base, sum_now;
    logic [NSW-1:0]         eff_n, eff_now, cur_n;
    logic [FW-1:0]          lat_factor, cur_factor;
    logic                   lat_bypass, cur_bypass;
    logic [IDW-1:0]         lat_id;
    logic                   err, err_in;
    logic [CHW:0]           kept_cnt, kept_base;
    logic [NCHAN-1:0]       keep_vec;
    logic                   accept, chan_end, last_ch, keep, hs, osi_end;
    logic [STDW-1:0]        std_rd;
    logic [SW-1:0]          smp_rd;

    // Effective bin count, clamped into 1..MAXS (R12)
    always_comb begin
        if (cfg_nsamp == 8'd0)        eff_now = NSW'(1);
        else if (cfg_nsamp > MAXS_B)  eff_now = NSW'(MAXS);
        else                          eff_now = NSW'(cfg_nsamp);
    end

    assign err_in     = (s_nsamp > MAXS_B) || (s_nsamp != cfg_nsamp);
    assign cur_n      = (state == ST_IDLE) ? eff_now    : eff_n;
    assign cur_factor = (state == ST_IDLE) ? cfg_factor : lat_factor;
    assign cur_bypass = (state == ST_IDLE) ? cfg_bypass : lat_bypass;
    assign kept_base  = (state == ST_IDLE) ? '0 : kept_cnt;

    assign accept   = s_valid && s_ready && ((state == ST_COLLECT) || s_first);
    assign acc_base = (si == '0) ? '0 : acc;
    assign sum_now  = acc_base + SUMW'($signed(s_data));
    assign chan_end = ({1'b0, si} == (cur_n - NSW'(1)));
    assign last_ch  = (ch_i == CHW'(NCHAN - 1));
    assign hs       = m_valid && m_ready;
    assign osi_end  = ({1'b0, osi} == (eff_n - NSW'(1)));

    zs_std_table #(.NCHAN(NCHAN), .STDW(STDW)) u_std (
        .clk   (clk),
        .we    (cfg_std_we),
        .waddr (cfg_std_addr),
        .wdata (cfg_std_data),
        .raddr (ch_i),
        .rdata (std_rd)
    );

    zs_sample_store #(.NCHAN(NCHAN), .MAXS(MAXS), .SW(SW)) u_store (
        .clk   (clk),
        .we    (accept),
        .wch   (ch_i),
        .wsi   (si),
        .wdata (s_data),
        .rch   (och),
        .rsi   (osi),
        .rdata (smp_rd)
    );

    zs_cut #(.SUMW(SUMW), .NSW(NSW), .STDW(STDW), .FW(FW), .FRAC(FRAC)) u_cut (
        .sum    (sum_now),
        .nbins  (cur_n),
        .sigma  (std_rd),
        .factor (cur_factor),
        .bypass (cur_bypass),
        .keep   (keep)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = (chan_end && last_ch) ? ST_HEAD : ST_COLLECT;
            end
            ST_COLLECT: begin
                if (accept && chan_end && last_ch) state_nx = ST_HEAD;
            end
            ST_HEAD: begin
                if (hs && hw == 2'd3) state_nx = (kept_cnt == '0) ? ST_IDLE : ST_SCAN;
            end
            ST_SCAN: begin
                if (keep_vec[och]) state_nx = ST_CHID;
            end
            ST_CHID: begin
                if (hs) state_nx = ST_SAMP;
            end
            ST_SAMP: begin
                if (hs && osi_end) state_nx = (och == last_keep) ? ST_IDLE : ST_SCAN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_i       <= '0;
            si         <= '0;
            acc        <= '0;
            eff_n      <= NSW'(1);
            err        <= 1'b0;
            lat_factor <= '0;
            lat_bypass <= 1'b0;
            lat_id     <= '0;
            kept_cnt   <= '0;
            last_keep  <= '0;
            keep_vec   <= '0;
            och        <= '0;
            osi        <= '0;
            hw         <= '0;
        end else begin
            if (state == ST_IDLE && accept) begin
                eff_n      <= eff_now;
                err        <= err_in;
                lat_factor <= cfg_factor;
                lat_bypass <= cfg_bypass;
                lat_id     <= cfg_chip_id;
            end
            if (accept) begin
                if (chan_end) begin
                    keep_vec[ch_i] <= keep;
                    if (keep) begin
                        kept_cnt  <= kept_base + (CHW+1)'(1);
                        last_keep <= ch_i;
                    end else begin
                        kept_cnt  <= kept_base;
                    end
                    si   <= '0;
                    ch_i <= last_ch ? '0 : ch_i + CHW'(1);
                end else begin
                    si       <= si + SIW'(1);
                    acc      <= sum_now;
                    kept_cnt <= kept_base;
                end
            end
            unique case (state)
                ST_HEAD: begin
                    if (hs) begin
                        hw <= hw + 2'd1;
                        if (hw == 2'd3) begin
                            och <= '0;
                            if (kept_cnt == '0) kept_cnt <= '0;
                        end
                    end
                end
                ST_SCAN: begin
                    if (!keep_vec[och]) och <= och + CHW'(1);
                end
                ST_CHID: begin
                    if (hs) osi <= '0;
                end
                ST_SAMP: begin
                    if (hs) begin
                        if (osi_end) begin
                            osi <= '0;
                            och <= (och == last_keep) ? '0 : och + CHW'(1);
                        end else begin
                            osi <= osi + SIW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        s_ready = 1'b0;
        m_valid = 1'b0;
        m_data  = '0;
        m_last  = 1'b0;
        unique case (state)
            ST_IDLE, ST_COLLECT: s_ready = 1'b1;
            ST_HEAD: begin
                m_valid = 1'b1;
                unique case (hw)
                    2'd0:    m_data = {8'(lat_id), 8'(kept_cnt)};
                    2'd1:    m_data = {8'(eff_n), 7'd0, err};
                    default: m_data = '0;
                endcase
                m_last = (hw == 2'd3) && (kept_cnt == '0);
            end
            ST_CHID: begin
                m_valid = 1'b1;
                m_data  = {8'h00, 8'(och)};
            end
            ST_SAMP: begin
                m_valid = 1'b1;
                m_data  = 16'(smp_rd);
                m_last  = osi_end && (och == last_keep);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/zs_formatter_chk.sv
module zs_formatter_chk
    import zs_pkg::*;
#(
    parameter int SW = 13
) (
    input logic        clk,
    input logic        rst_n,
    input logic        s_ready,
    input logic        m_valid,
    input logic        m_ready,
    input logic [15:0] m_data,
    input logic        m_last,
    input zs_state_e   state
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!m_valid && !m_last && s_ready)
                else $error("R1 outputs active during reset");
        end
    end

    assert_ready_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !m_valid);

    assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid);

    assert_idle_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_last) |=> s_ready);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    assert_sample_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMP) |-> (m_data[15:SW] == '0));
endmodule

bind zs_formatter zs_formatter_chk #(.SW(SW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_ready (s_ready),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_last  (m_last),
    .state   (state)
);

// File: tb/zs_formatter_tb.sv
`timescale 1ns/1ps
module zs_formatter_tb;
    localparam int NCHAN = 128;
    localparam int MAXS  = 16;
    localparam int MAXW  = 4 + NCHAN * (MAXS + 1);
    localparam int NVEC  = 9;

    // {bypass, factor, cfg_nsamp, s_nsamp, pattern, seed, stray beats}
    localparam logic [38:0] VEC [NVEC] = '{
        {1'b0, 8'h0D, 8'd2,  8'd2,  2'd0, 8'd3,  4'd0},  // R4 typical cut
        {1'b0, 8'h10, 8'd3,  8'd3,  2'd1, 8'd0,  4'd0},  // R4 equality edge
        {1'b1, 8'h0D, 8'd2,  8'd2,  2'd2, 8'd0,  4'd0},  // R5 bypass
        {1'b0, 8'h0D, 8'd2,  8'd2,  2'd2, 8'd0,  4'd0},  // R8 empty frame
        {1'b0, 8'h0D, 8'd4,  8'd5,  2'd0, 8'd7,  4'd0},  // R9 mismatch
        {1'b0, 8'h0D, 8'd2,  8'd2,  2'd0, 8'd9,  4'd3},  // R2 stray beats
        {1'b0, 8'h08, 8'd16, 8'd16, 2'd0, 8'd5,  4'd0},  // R3 max bins
        {1'b0, 8'h0D, 8'd20, 8'd20, 2'd0, 8'd1,  4'd0},  // R12 clamp, R9 over
        {1'b0, 8'h00, 8'd1,  8'd1,  2'd0, 8'd4,  4'd1}   // R4 zero factor
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_chip_id = '0;
    logic [7:0]  cfg_nsamp = 8'd2;
    logic [7:0]  cfg_factor = '0;
    logic        cfg_bypass = 1'b0;
    logic        cfg_std_we = 1'b0;
    logic [6:0]  cfg_std_addr = '0;
    logic [7:0]  cfg_std_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic        s_first = 1'b0;
    logic [7:0]  s_nsamp = '0;
    logic [12:0] s_data = '0;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [15:0] m_data;
    logic        m_last;

    int total = 0;
    int bad   = 0;
    int tb_std [NCHAN];
    int exp_data [MAXW];
    bit exp_last [MAXW];
    string exp_tag [MAXW];
    int exp_n;
    int rdy_k = 0;

    always #2.5 clk = ~clk;

    zs_formatter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_chip_id(cfg_chip_id), .cfg_nsamp(cfg_nsamp),
        .cfg_factor(cfg_factor), .cfg_bypass(cfg_bypass), .cfg_std_we(cfg_std_we),
        .cfg_std_addr(cfg_std_addr), .cfg_std_data(cfg_std_data), .s_valid(s_valid),
        .s_ready(s_ready), .s_first(s_first), .s_nsamp(s_nsamp), .s_data(s_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int smp_of(int pat, int ch, int s, int seed);
        if (pat == 0) return ((ch * 7 + s * 13 + seed * 11) % 61) - 20;
        if (pat == 1) return (ch % 2 == 0) ? tb_std[ch] : tb_std[ch] - 1;
        return -5 - s;
    endfunction

    function automatic int eff_of(int c);
        if (c == 0) return 1;
        if (c > MAXS) return MAXS;
        return c;
    endfunction

    task automatic build_exp(input int id, input bit byp, input int fac, input int cn,
                             input int in_n, input int pat, input int seed);
        int eff = eff_of(cn);
        int errb = (in_n > MAXS || in_n != cn) ? 1 : 0;
        int kept = 0;
        int last_ch = -1;
        bit kv [NCHAN];
        for (int ch = 0; ch < NCHAN; ch++) begin
            int sum = 0;
            for (int s = 0; s < eff; s++) sum += smp_of(pat, ch, s, seed);
            kv[ch] = byp || (sum * 16 >= eff * tb_std[ch] * fac);
            if (kv[ch]) begin kept++; last_ch = ch; end
        end
        exp_data[0] = (id << 8) | kept;  exp_tag[0] = "R4 header word0 count";
        exp_data[1] = (eff << 8) | errb; exp_tag[1] = "R9 header word1";
        exp_data[2] = 0;                 exp_tag[2] = "R6 header word2";
        exp_data[3] = 0;                 exp_tag[3] = "R6 header word3";
        for (int i = 0; i < 4; i++) exp_last[i] = 1'b0;
        exp_last[3] = (kept == 0);
        exp_n = 4;
        for (int ch = 0; ch < NCHAN; ch++) begin
            if (kv[ch]) begin
                exp_data[exp_n] = ch; exp_tag[exp_n] = "R7 channel id";
                exp_last[exp_n] = 1'b0; exp_n++;
                for (int s = 0; s < eff; s++) begin
                    exp_data[exp_n] = smp_of(pat, ch, s, seed) & 16'h1FFF;
                    exp_tag[exp_n]  = "R7 sample word";
                    exp_last[exp_n] = (ch == last_ch) && (s == eff - 1);
                    exp_n++;
                end
            end
        end
    endtask

    task automatic drive_beat(input bit first, input int nsamp, input int val);
        @(negedge clk);
        s_valid = 1'b1;
        s_first = first;
        s_nsamp = 8'(nsamp);
        s_data  = 13'(val);
        while (!s_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_frame(input int in_n, input int eff, input int pat,
                              input int seed, input int stray);
        for (int j = 0; j < stray; j++) drive_beat(1'b0, in_n, 4000 + j);  // R2
        for (int ch = 0; ch < NCHAN; ch++)
            for (int s = 0; s < eff; s++)
                drive_beat(ch == 0 && s == 0, in_n, smp_of(pat, ch, s, seed));
        @(negedge clk);
        s_valid = 1'b0;
        s_first = 1'b0;
    endtask

    task automatic recv_frame();
        int idx = 0;
        bit done = 1'b0;
        while (!done) begin
            @(negedge clk);
            m_ready = (rdy_k % 4) != 3;  // backpressure, R10
            rdy_k++;
            if (m_valid && m_ready) begin
                if (idx == 0) check(s_ready == 1'b0, "R3 input blocked while sending", s_ready, 0);
                if (idx < exp_n) begin
                    check(m_data == 16'(exp_data[idx]), exp_tag[idx], m_data, exp_data[idx]);
                    check(m_last == exp_last[idx], "R8 last flag", m_last, exp_last[idx]);
                end
                idx++;
                if (m_last || idx > exp_n) done = 1'b1;
            end
        end
        check(idx == exp_n, "R8 frame length", idx, exp_n);
        @(posedge clk);
        #1 m_ready = 1'b0;
    endtask

    task automatic run_frame(input int id, input bit byp, input int fac, input int cn,
                             input int in_n, input int pat, input int seed, input int stray);
        @(negedge clk);
        cfg_chip_id = 4'(id);
        cfg_bypass  = byp;
        cfg_factor  = 8'(fac);
        cfg_nsamp   = 8'(cn);
        build_exp(id, byp, fac, cn, in_n, pat, seed);
        fork
            send_frame(in_n, eff_of(cn), pat, seed, stray);
            recv_frame();
        join
    endtask

    task automatic write_std(input int ch, input int v);
        @(negedge clk);
        cfg_std_we   = 1'b1;
        cfg_std_addr = 7'(ch);
        cfg_std_data = 8'(v);
        @(negedge clk);
        cfg_std_we = 1'b0;
        tb_std[ch] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!m_valid && !m_last && s_ready, "R1 during reset", {m_valid, s_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!m_valid && !m_last && s_ready, "R1 after reset", {m_valid, s_ready}, 1);

        for (int ch = 0; ch < NCHAN; ch++) write_std(ch, (ch * 5) % 23 + 1);  // R11

        for (int v = 0; v < NVEC; v++)
            run_frame(v, VEC[v][38], VEC[v][37:30], VEC[v][29:22], VEC[v][21:14],
                      VEC[v][13:12], VEC[v][11:4], VEC[v][3:0]);

        // R11: raise every noise value so nothing passes, then open channel 10
        for (int ch = 0; ch < NCHAN; ch++) write_std(ch, 255);
        write_std(10, 0);
        run_frame(11, 1'b0, 8'h10, 2, 2, 0, 2, 0);

        // R1: reset in the middle of a trigger abandons it
        for (int ch = 0; ch < NCHAN; ch++) write_std(ch, (ch * 3) % 17 + 2);
        cfg_nsamp = 8'd2;
        for (int j = 0; j < 50; j++) drive_beat(j == 0, 2, j);
        @(negedge clk);
        s_valid = 1'b0;
        rst_n   = 1'b0;
        @(negedge clk);
        check(!m_valid && s_ready, "R1 mid-frame reset", {m_valid, s_ready}, 1);
        rst_n = 1'b1;
        run_frame(6, 1'b0, 8'h0D, 2, 2, 0, 12, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule